// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block raises a recurring interrupt at one of six rates, all derived from a 256 Hz tick pulse that a prescaler outside the block supplies. Software picks the rate through a 3-bit select field in a one-byte control register. Each time the selected period elapses, the hardware sets a pending flag in the same byte, and the interrupt line stays high for as long as that flag is set and a valid rate is selected.

The register is written through a single-cycle write strobe with a data byte. It is read back at any time on a separate read bus. Software acknowledges an interrupt by writing the byte back with the flag bit at 0. A select value of zero, or the reserved value seven, stops the generator. Changing the select value restarts the internal divider, so the first event at the new rate arrives one full new period after the write.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset the read byte is 0x00 and the interrupt output is low.
- R2: A write stores data bits 6:4 as the select field, which reads back in bits 6:4. Bits 3:0 always read 0.
- R3: With select code 1, 2, 3, 4, 5 or 6, the flag is set on the 1st, 4th, 16th, 64th, 128th or 256th tick after the divider (re)starts, and on the tick that completes each further period.
- R4: Select codes 0 and 7 disable the generator: no number of ticks sets the flag.
- R5: The flag reads in bit 7. A write with data bit 7 at 0 clears it.
- R6: A write with data bit 7 at 1 never sets the flag. It leaves the flag unchanged.
- R7: The interrupt output is high exactly when the flag is set and the select code is 1 to 6. A set flag under code 0 or 7 keeps the output low.
- R8: A write whose select value differs from the stored one restarts the divider. A write with the same select value does not disturb it.
- R9: A period that ends while the flag is already set leaves it set. After one clear, no second event is left pending.
- R10: When a period ends in the same cycle as a write that clears the flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_256 | input | 1 | One-cycle pulse at 256 Hz from the prescaler |
| cfg_wr_en | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Write data: bit 7 flag (0 clears), bits 6:4 select |
| cfg_rdata | output | 8 | Read data: bit 7 flag, bits 6:4 select, bits 3:0 zero |
| irq | output | 1 | Periodic interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is a hardware flag set and a software acknowledge. The bench provokes it by driving a tick that completes a code-1 period together with a clearing write, and it expects the flag to read 1 afterwards. The second is a write that changes the select code in the middle of a period. The bench judges it by counting the ticks to the next flag against the new code's full period. It also checks that rewriting the same code leaves the divider's progress intact.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int SEL_W    = 3;
  localparam int SEL_LSB  = 4;
  localparam int FLAG_BIT = 7;
  localparam int BYTE_W   = 8;

  typedef enum logic [SEL_W-1:0] {
    RATE_OFF   = 3'd0,
    RATE_256HZ = 3'd1,
    RATE_64HZ  = 3'd2,
    RATE_16HZ  = 3'd3,
    RATE_4HZ   = 3'd4,
    RATE_2HZ   = 3'd5,
    RATE_1HZ   = 3'd6,
    RATE_RSVD  = 3'd7
  } rate_sel_e;

  // log2 of the period in ticks for each select code
  function automatic logic [3:0] period_log2(rate_sel_e code);
    case (code)
      RATE_256HZ: period_log2 = 4'd0;
      RATE_64HZ:  period_log2 = 4'd2;
      RATE_16HZ:  period_log2 = 4'd4;
      RATE_4HZ:   period_log2 = 4'd6;
      RATE_2HZ:   period_log2 = 4'd7;
      RATE_1HZ:   period_log2 = 4'd8;
      default:    period_log2 = 4'd0;
    endcase
  endfunction

  function automatic logic rate_active(rate_sel_e code);
    rate_active = (code != RATE_OFF) && (code != RATE_RSVD);
  endfunction

endpackage

// File: rtl/pit_rate_decode.sv
module pit_rate_decode
  import pit_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  rate_sel_e        sel_i,
  output logic             enable_o,
  output logic [DIV_W-1:0] last_o
);

  logic [3:0]     shift;
  logic [DIV_W:0] span;

  always_comb begin
    shift    = period_log2(sel_i);
    enable_o = rate_active(sel_i);
    span     = '0;
    span[shift] = 1'b1;
    last_o   = DIV_W'(span - 1'b1);
  end

endmodule

// File: rtl/pit_divider.sv
module pit_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] last_i,
  output logic             hit_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  always_comb begin
    at_last = (cnt_q == last_i);
    hit_o   = tick_i && enable_i && !restart_i && at_last;
    cnt_en  = restart_i || !enable_i || tick_i;
    cnt_d   = cnt_q;
    if (restart_i || !enable_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (cnt_q == '0));

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i |-> (cnt_q <= last_i));

  assert_hit_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> tick_i);

endmodule

// File: rtl/pit_flag.sv
module pit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = set_i;   // set wins over a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);

  assert_only_hw_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_i));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pit_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_256,
  input  logic        cfg_wr_en,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic        irq
);

  rate_sel_e        sel_q, sel_d;
  logic             sel_en;
  logic             restart;
  logic             enable;
  logic [DIV_W-1:0] last;
  logic             hit;
  logic             flag;
  logic             flag_clr;

  always_comb begin
    sel_d    = rate_sel_e'(cfg_wdata[SEL_LSB +: SEL_W]);
    sel_en   = cfg_wr_en;
    restart  = cfg_wr_en && (sel_d != sel_q);
    flag_clr = cfg_wr_en && !cfg_wdata[FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= RATE_OFF;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  pit_rate_decode #(.DIV_W(DIV_W)) u_decode (
    .sel_i    (sel_q),
    .enable_o (enable),
    .last_o   (last)
  );

  pit_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_256),
    .enable_i  (enable),
    .restart_i (restart),
    .last_i    (last),
    .hit_o     (hit)
  );

  pit_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit),
    .clr_i  (flag_clr),
    .flag_o (flag)
  );

  always_comb begin
    cfg_rdata = {flag, sel_q, 4'b0000};
    irq       = flag && enable;
  end

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[6:4] == 3'd0 || cfg_rdata[6:4] == 3'd7) |-> !irq);

endmodule

// File: tb/periodic_irq_gen_test.sv
module periodic_irq_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_256;
  logic       cfg_wr_en;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  periodic_irq_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_256  (tick_256),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq       (irq)
  );

  // {code[3:0], ticks[11:0], expected flag[3:0]}; R3 and R4 table
  localparam logic [19:0] VEC [13] = '{
    {4'd1, 12'd1,   4'd1},
    {4'd2, 12'd3,   4'd0},
    {4'd2, 12'd4,   4'd1},
    {4'd3, 12'd15,  4'd0},
    {4'd3, 12'd16,  4'd1},
    {4'd4, 12'd63,  4'd0},
    {4'd4, 12'd64,  4'd1},
    {4'd5, 12'd127, 4'd0},
    {4'd5, 12'd128, 4'd1},
    {4'd6, 12'd255, 4'd0},
    {4'd6, 12'd256, 4'd1},
    {4'd0, 12'd300, 4'd0},
    {4'd7, 12'd300, 4'd0}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    cfg_wr_en = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_wdata = 8'h00;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_256 = 1'b1;
      @(negedge clk);
      tick_256 = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    tick_256  = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 rdata", cfg_rdata, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2: select readback, low bits read zero
    wr(8'h5F);
    check("R2 readback", cfg_rdata, 8'h50);

    // Table walk: R3 periods, R4 disabled codes, R7 irq
    for (int v = 0; v < 13; v++) begin
      logic [3:0]  code;
      logic [11:0] n;
      logic        ef;
      logic        act;
      code = VEC[v][19:16];
      n    = VEC[v][15:4];
      ef   = VEC[v][0];
      act  = (code != 4'd0) && (code != 4'd7);
      wr(8'h00);
      wr({1'b0, code[2:0], 4'h0});
      ticks(int'(n));
      if (act) begin
        check("R3 flag", {7'd0, cfg_rdata[7]}, {7'd0, ef});
        check("R7 irq", {7'd0, irq}, {7'd0, ef});
      end else begin
        check("R4 flag", {7'd0, cfg_rdata[7]}, 8'h00);
      end
    end

    // R5: clear by writing bit 7 = 0
    wr(8'h00); wr(8'h10); ticks(1);
    check("R5 set", cfg_rdata, 8'h90);
    wr(8'h10);
    check("R5 clear", cfg_rdata, 8'h10);

    // R6: writing 1 to the flag does not set it
    wr(8'h00); wr(8'h20);
    wr(8'hA0);
    check("R6 no sw set", cfg_rdata, 8'h20);
    check("R6 irq", {7'd0, irq}, 8'h00);

    // R7: flag set but code 0 gates irq
    wr(8'h00); wr(8'h10); ticks(1);
    wr(8'h80);
    check("R7 flag kept", cfg_rdata, 8'h80);
    check("R7 irq off", {7'd0, irq}, 8'h00);

    // R8: select change restarts; same select rewrite does not
    wr(8'h00); wr(8'h20); ticks(2);
    wr(8'h30); ticks(15);
    check("R8 restart early", {7'd0, cfg_rdata[7]}, 8'h00);
    ticks(1);
    check("R8 restart full", {7'd0, cfg_rdata[7]}, 8'h01);
    wr(8'h00); wr(8'h20); ticks(2);
    wr(8'h20); ticks(2);
    check("R8 same code keeps", {7'd0, cfg_rdata[7]}, 8'h01);

    // R9: two periods while set, one clear leaves nothing pending
    wr(8'h00); wr(8'h10); ticks(2);
    check("R9 still set", cfg_rdata, 8'h90);
    wr(8'h10);
    repeat (3) @(negedge clk);
    check("R9 no pending", cfg_rdata, 8'h10);

    // R10: hit and clear in the same cycle
    wr(8'h00); wr(8'h10); ticks(1);
    tick_256  = 1'b1;
    cfg_wr_en = 1'b1;
    cfg_wdata = 8'h10;
    @(negedge clk);
    tick_256  = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_wdata = 8'h00;
    check("R10 set wins", cfg_rdata, 8'h90);
    check("R10 irq", {7'd0, irq}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule